// File: doc/BRIEF.md
# Three-Source Interrupt Collector for an 8-bit Core

This block collects the interrupt events of a small 8-bit microcontroller and turns them into one interrupt request for the core and one wake-up signal. There are three sources. The first is an external pin whose active edge, rising or falling, is chosen by an edge-select input. The second is an overflow strobe from an 8-bit timer. The third is a change on four upper I/O port bits. Each source owns a sticky flag and an enable bit, and one global enable sits above them. All of these live in one 8-bit control/status register that software reads and writes.

A flag is set whenever its event occurs, whatever the enables hold. Only a software write clears it, and a hardware set in the same cycle as a clearing write wins. The port-change source compares the live port bits against a copy that is reloaded on every port read and on every register write. The comparison is made only on the first-phase strobe of each instruction cycle, so a pulse shorter than one instruction cycle is missed. While the core sleeps, any enabled flag raises the wake output. The global enable does not gate wake-up. It only gates the request that makes the core vector.

Top module: `irq_hub`

## Requirements
- R1: After reset the register reads 8'h00 and both irq_req and wake are 0.
- R2: Register bits: 0 port-change flag, 1 pin flag, 2 timer flag, 3 port-change enable, 4 pin enable, 5 timer enable, 7 global enable. Bit 6 always reads 0. Writing 8'hFF reads back 8'hBF.
- R3: With edge_rise=1, a rising edge on ext_pin sets bit 1 within four clocks. A falling edge does not set it.
- R4: With edge_rise=0, a falling edge on ext_pin sets bit 1. A rising edge does not set it.
- R5: A one-clock pulse on tmr_ovf sets bit 2.
- R6: On a clock with q1_stb=1, port_hi differing from the stored copy sets bit 0. A change that reverts before the next strobe sets nothing.
- R7: A port_rd pulse or any register write reloads the stored copy from port_hi, so that value no longer counts as a change.
- R8: Flags set with all enables at 0 and stay set until a write puts 0 in them.
- R9: When a hardware set and a write of 0 to the same flag land in the same clock, the flag ends up 1.
- R10: irq_req is 1 exactly when bit 7 is 1 and some flag is 1 together with its enable.
- R11: wake is 1 exactly when sleeping is 1 and some flag is 1 together with its enable, whatever bit 7 holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| q1_stb | input | 1 | First-phase strobe, one clock per instruction cycle |
| ext_pin | input | 1 | External interrupt pin |
| edge_rise | input | 1 | 1 selects rising edge, 0 selects falling |
| tmr_ovf | input | 1 | Timer rollover strobe |
| port_hi | input | 4 | Upper port bits watched for change |
| port_rd | input | 1 | Port read strobe, reloads the stored copy |
| csr_we | input | 1 | Register write enable |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Register read data |
| sleeping | input | 1 | Core is asleep |
| irq_req | output | 1 | Interrupt request to the core |
| wake | output | 1 | Wake-up request |

## Verification
The hardest case to reach is a port change that has to be missed: the port must change and change back entirely between two first-phase strobes. The stimulus holds q1_stb low across the whole excursion and strobes only afterwards. A second hard case is a port change hidden by a reload, which a port_rd pulse placed before the strobe produces. A third is the race between a hardware set and a clearing write. The bench drives tmr_ovf and a register write of zero on the same clock edge to create it.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
   localparam int NSRC    = 3;
   localparam int SRC_PCH = 0;
   localparam int SRC_EXT = 1;
   localparam int SRC_TMR = 2;
   localparam int CSR_W   = 8;
   localparam int EN_LSB  = NSRC;
   localparam int GIE_BIT = CSR_W - 1;
endpackage

// File: rtl/irq_hub_edge.sv
module irq_hub_edge #(
   parameter int SYNC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic rise_sel,
   output logic hit
);
   logic lvl, lvl_d;

   generate
      if (SYNC < 0) begin : g_bad
         $error("SYNC must not be negative");
      end
      if (SYNC == 0) begin : g_direct
         assign lvl = pin;
      end else begin : g_sync
         logic [SYNC-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '0;
            else begin
               sr[0] <= pin;
               for (int i = 1; i < SYNC; i++) sr[i] <= sr[i-1];
            end
         end
         assign lvl = sr[SYNC-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= 1'b0;
      else        lvl_d <= lvl;
   end

   assign hit = rise_sel ? (lvl & ~lvl_d) : (~lvl & lvl_d);

   // R3 R4: one edge gives a single-clock event unless the polarity flips
   a_r3_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (!hit || rise_sel != $past(rise_sel)));
endmodule

// File: rtl/irq_hub_pchg.sv
module irq_hub_pchg #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         q1_stb,
   input  logic [W-1:0] pins,
   input  logic         load,
   output logic         hit
);
   logic [W-1:0] snap;

   generate
      if (W < 1) begin : g_bad
         $error("W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    snap <= '0;
      else if (load) snap <= pins;
   end

   assign hit = q1_stb && (pins != snap);

   // R7: the stored copy moves only on a reload
   a_r7_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> snap == $past(snap));
endmodule

// File: rtl/irq_hub_flag.sv
module irq_hub_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic we,
   input  logic wbit,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (we)  q <= wbit;
   end

   // R9: a hardware event is never lost
   a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> q);
   // R8: without a write or an event the flag holds
   a_r8_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!set && !we) |=> q == $past(q));
endmodule

// File: rtl/irq_hub.sv
module irq_hub
   import irq_hub_pkg::*;
#(
   parameter int PORT_W   = 4,
   parameter int EXT_SYNC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              q1_stb,
   input  logic              ext_pin,
   input  logic              edge_rise,
   input  logic              tmr_ovf,
   input  logic [PORT_W-1:0] port_hi,
   input  logic              port_rd,
   input  logic              csr_we,
   input  logic [CSR_W-1:0]  csr_wdata,
   output logic [CSR_W-1:0]  csr_rdata,
   input  logic              sleeping,
   output logic              irq_req,
   output logic              wake
);
   localparam int SPARE_W = GIE_BIT - EN_LSB - NSRC;

   generate
      if (SPARE_W < 0) begin : g_bad
         $error("register too narrow for the sources");
      end
   endgenerate

   logic [NSRC-1:0] set_ev, flags, en;
   logic            gie, ext_hit, pch_hit;

   irq_hub_edge #(.SYNC(EXT_SYNC)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin(ext_pin), .rise_sel(edge_rise), .hit(ext_hit));

   irq_hub_pchg #(.W(PORT_W)) u_pchg (
      .clk(clk), .rst_n(rst_n), .q1_stb(q1_stb), .pins(port_hi),
      .load(port_rd | csr_we), .hit(pch_hit));

   always_comb begin
      set_ev          = '0;
      set_ev[SRC_PCH] = pch_hit;
      set_ev[SRC_EXT] = ext_hit;
      set_ev[SRC_TMR] = tmr_ovf;
   end

   generate
      for (genvar s = 0; s < NSRC; s++) begin : g_flag
         irq_hub_flag u_flag (
            .clk(clk), .rst_n(rst_n), .set(set_ev[s]), .we(csr_we),
            .wbit(csr_wdata[s]), .q(flags[s]));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en  <= '0;
         gie <= 1'b0;
      end else if (csr_we) begin
         en  <= csr_wdata[EN_LSB +: NSRC];
         gie <= csr_wdata[GIE_BIT];
      end
   end

   logic pend;
   assign pend = |(flags & en);

   generate
      if (SPARE_W > 0) begin : g_spare
         assign csr_rdata = {gie, {SPARE_W{1'b0}}, en, flags};
      end else begin : g_full
         assign csr_rdata = {gie, en, flags};
      end
   endgenerate

   assign irq_req = gie & pend;
   assign wake    = sleeping & pend;

   // R10: no request while the global enable is off
   a_r10_gie_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !csr_rdata[GIE_BIT] |-> !irq_req);
   // R11: wake only while sleeping
   a_r11_wake_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      !sleeping |-> !wake);
   // R2: spare bit reads zero
   a_r2_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
      csr_rdata[GIE_BIT-1] == 1'b0);
endmodule

// File: tb/irq_hub_tb_top.sv
module irq_hub_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       q1_stb = 1'b0, ext_pin = 1'b0, edge_rise = 1'b1, tmr_ovf = 1'b0;
   logic [3:0] port_hi = 4'h0;
   logic       port_rd = 1'b0, csr_we = 1'b0, sleeping = 1'b0;
   logic [7:0] csr_wdata = 8'h00, csr_rdata;
   logic       irq_req, wake;
   int         n_chk = 0, n_err = 0;

   always #4 clk = ~clk;

   irq_hub dut_i (
      .clk(clk), .rst_n(rst_n), .q1_stb(q1_stb), .ext_pin(ext_pin),
      .edge_rise(edge_rise), .tmr_ovf(tmr_ovf), .port_hi(port_hi),
      .port_rd(port_rd), .csr_we(csr_we), .csr_wdata(csr_wdata),
      .csr_rdata(csr_rdata), .sleeping(sleeping), .irq_req(irq_req), .wake(wake));

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic wr(input logic [7:0] d);
      csr_we = 1'b1; csr_wdata = d;
      tick();
      csr_we = 1'b0;
   endtask

   task automatic strobe();
      q1_stb = 1'b1; tick(); q1_stb = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 csr", csr_rdata, 8'h00);
      chk("R1 irq", {7'b0, irq_req}, 8'h00);
      chk("R1 wake", {7'b0, wake}, 8'h00);
   endtask

   task automatic t_csr();
      wr(8'hFF); chk("R2 all ones", csr_rdata, 8'hBF);
      wr(8'h00); chk("R2 cleared", csr_rdata, 8'h00);
   endtask

   task automatic t_ext_rise();
      edge_rise = 1'b1; ext_pin = 1'b1; tick(4);
      chk("R3 rising sets", csr_rdata & 8'h02, 8'h02);
      ext_pin = 1'b0; tick(4); wr(8'h00); tick(4);
      chk("R3 falling ignored", csr_rdata & 8'h02, 8'h00);
   endtask

   task automatic t_ext_fall();
      edge_rise = 1'b0; ext_pin = 1'b1; tick(4);
      chk("R4 rising ignored", csr_rdata & 8'h02, 8'h00);
      ext_pin = 1'b0; tick(4);
      chk("R4 falling sets", csr_rdata & 8'h02, 8'h02);
      wr(8'h00); edge_rise = 1'b1;
   endtask

   task automatic t_tmr();
      tmr_ovf = 1'b1; tick(); tmr_ovf = 1'b0;
      chk("R5 timer flag", csr_rdata, 8'h04);
      tick(5);
      chk("R8 flag held", csr_rdata, 8'h04);
      wr(8'h00); chk("R8 cleared by write", csr_rdata, 8'h00);
   endtask

   task automatic t_pchg();
      port_hi = 4'h5; tick(2); port_hi = 4'h0; tick(); strobe();
      chk("R6 glitch ignored", csr_rdata & 8'h01, 8'h00);
      port_hi = 4'hA; strobe();
      chk("R6 change sets", csr_rdata & 8'h01, 8'h01);
      wr(8'h00); strobe();
      chk("R7 write reloads", csr_rdata & 8'h01, 8'h00);
      port_hi = 4'h3; port_rd = 1'b1; tick(); port_rd = 1'b0; strobe();
      chk("R7 read reloads", csr_rdata & 8'h01, 8'h00);
   endtask

   task automatic t_priority();
      csr_we = 1'b1; csr_wdata = 8'h00; tmr_ovf = 1'b1;
      tick();
      csr_we = 1'b0; tmr_ovf = 1'b0;
      chk("R9 set beats clear", csr_rdata & 8'h04, 8'h04);
      wr(8'h00);
   endtask

   task automatic t_irq();
      tmr_ovf = 1'b1; tick(); tmr_ovf = 1'b0;
      wr(8'h24); chk("R10 gie off", {7'b0, irq_req}, 8'h00);
      wr(8'hA4); chk("R10 request", {7'b0, irq_req}, 8'h01);
      wr(8'h84); chk("R10 enable off", {7'b0, irq_req}, 8'h00);
      wr(8'h00);
   endtask

   task automatic t_wake();
      sleeping = 1'b1;
      tmr_ovf = 1'b1; tick(); tmr_ovf = 1'b0;
      chk("R11 disabled no wake", {7'b0, wake}, 8'h00);
      wr(8'h24); chk("R11 wake without gie", {7'b0, wake}, 8'h01);
      chk("R10 no irq without gie", {7'b0, irq_req}, 8'h00);
      sleeping = 1'b0; tick();
      chk("R11 awake", {7'b0, wake}, 8'h00);
      wr(8'h00);
   endtask

   initial begin
      tick(2);
      t_reset();
      rst_n = 1'b1; tick();
      t_reset();
      t_csr();
      t_ext_rise();
      t_ext_fall();
      t_tmr();
      t_pchg();
      t_priority();
      t_irq();
      t_wake();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #400000;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule